// File: doc/BRIEF.md
# Shared Bus Arbiter for Two DMA Channels and a PCI Requester

This block decides who drives a shared processor/memory data bus. There are three requesters: one external PCI master path and two DMA channels. The block registers a one-hot grant. The owner keeps that grant until it reaches a transaction boundary, so no owner is ever cut off partway through a transaction. If the PCI requester raises its request while a DMA channel owns the bus, it gets a one-cycle retry pulse and is not queued. It keeps its request asserted and wins at the next arbitration point.

The DMA engine supplies inputs for each channel:
- a transfer type (local-to-local or local-to-PCI);
- a read/write flag;
- a strobe for each completed 32-byte line;
- an end-of-transfer flag;
- a 2-bit spacing code.

From these the block counts lines and decides where each DMA transaction ends. A nonzero spacing code does two things: it shortens every transaction to one line, and it blocks the channel for four cycles per code step after it releases the bus. All pins are plain level or strobe controls, so there is no valid/ready interface. A requester that is not granted simply keeps its request high.

Top module: `shbus_arbiter`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, pci_gnt, dma_gnt and pci_retry are all 0.
- R2: At an arbitration point (bus idle, or the owner releasing this cycle) with pci_req high, pci_gnt is 1 on the next cycle, even when DMA channels also request.
- R3: When both DMA channels are eligible and PCI is idle, the channel opposite to the one that last released a DMA grant wins. Channel 0 wins first after reset. A PCI grant does not change this preference.
- R4: pci_gnt stays 1 for as long as pci_req stays high. It drops one cycle after pci_req falls.
- R5: pci_retry pulses for exactly one cycle, one cycle after pci_req rises while a DMA channel owns the bus and is not releasing it.
- R6: A DMA channel keeps its grant until its transaction boundary, or until it drops its request. Nobody preempts it.
- R7: For a local-to-local transfer (dma_to_pci=0) with spacing code 0: a write (dma_wr=1) ends after one line strobe, and a read ends after two line strobes.
- R8: With a nonzero spacing code (channel k uses dma_dly[2k+1:2k]), every transaction ends after one line strobe.
- R9: For a local-to-PCI transfer (dma_to_pci=1) with spacing code 0, the transaction ends after 128 line strobes, or earlier on a strobe with dma_last high.
- R10: After channel k releases with spacing code g>0, that channel is not granted for exactly 4*g cycles.
- R11: At most one of pci_gnt and the dma_gnt bits is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pci_req | input | 1 | PCI master wants the bus (level) |
| dma_req | input | 2 | DMA channel requests, bit k = channel k |
| dma_to_pci | input | 2 | 1 = local-to-PCI transfer, 0 = local-to-local |
| dma_wr | input | 2 | 1 = write to local memory, 0 = read |
| dma_dly | input | 4 | Spacing code, channel k in bits [2k+1:2k] |
| dma_line_done | input | 2 | One-cycle strobe per completed line |
| dma_last | input | 2 | Qualifies a line strobe as the final one of the transfer |
| pci_gnt | output | 1 | PCI owns the bus |
| pci_retry | output | 1 | One-cycle retry to the PCI master |
| dma_gnt | output | 2 | DMA channel k owns the bus |

## Verification
The retry pulse and the DMA boundary can both happen at the same arbitration point, so the bench checks them together. A PCI request is raised while channel 0 owns the bus. The first cycle after that must show the retry and no grant change. The bench then counts line strobes until pci_gnt appears. That count must equal the boundary length for the mode, which is checked across a table of type, direction and spacing combinations. Round-robin hand-off and the spacing gap also meet at a release. Two directed sequences cover this: one makes both channels alternate, and one counts the idle cycles before a spaced channel returns.

// File: rtl/shbus_pkg.sv
package shbus_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_PCI  = 2'd1,
    OWN_D0   = 2'd2,
    OWN_D1   = 2'd3
  } owner_e;
endpackage

// File: rtl/shbus_span.sv
// Per-channel line counter that marks the end of a DMA transaction.
module shbus_span #(
  parameter int LINES_MAX = 128,
  parameter int DLY_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             own,
  input  logic             line_done,
  input  logic             last,
  input  logic             to_pci,
  input  logic             wr,
  input  logic [DLY_W-1:0] dly,
  output logic             boundary
);
  localparam int CW = $clog2(LINES_MAX);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_m1;

  always_comb begin
    if (dly != '0)   lim_m1 = '0;
    else if (to_pci) lim_m1 = CW'(LINES_MAX - 1);
    else if (wr)     lim_m1 = '0;
    else             lim_m1 = CW'(1);
  end

  assign boundary = own && line_done && (last || cnt_q == lim_m1);

  always_ff @(posedge clk) begin
    if (!rst_n || !own) cnt_q <= '0;
    else if (boundary)  cnt_q <= '0;
    else if (line_done) cnt_q <= cnt_q + CW'(1);
  end

  AST_SPAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    own |-> cnt_q <= lim_m1); // R9
endmodule

// File: rtl/shbus_gap.sv
// Post-release spacing timer for one DMA channel.
module shbus_gap #(
  parameter int DLY_W    = 2,
  parameter int GAP_UNIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done,
  input  logic [DLY_W-1:0] dly,
  output logic             busy
);
  localparam int GMAX = ((1 << DLY_W) - 1) * GAP_UNIT;
  localparam int GW   = $clog2(GMAX + 1);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (done)           cnt_q <= (dly == '0) ? '0 : GW'(int'(dly) * GAP_UNIT - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - GW'(1);
  end

  assign busy = (cnt_q != '0);

  AST_GAP_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && dly != '0) |=> busy); // R10
endmodule

// File: rtl/shbus_arbiter.sv
module shbus_arbiter
  import shbus_pkg::*;
#(
  parameter int LINE_BYTES   = 32,
  parameter int STREAM_BYTES = 4096,
  parameter int DLY_W        = 2,
  parameter int GAP_UNIT     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pci_req,
  input  logic [1:0]         dma_req,
  input  logic [1:0]         dma_to_pci,
  input  logic [1:0]         dma_wr,
  input  logic [2*DLY_W-1:0] dma_dly,
  input  logic [1:0]         dma_line_done,
  input  logic [1:0]         dma_last,
  output logic               pci_gnt,
  output logic               pci_retry,
  output logic [1:0]         dma_gnt
);
  localparam int NCH       = 2;
  localparam int LINES_MAX = STREAM_BYTES / LINE_BYTES;

  owner_e   owner_q, owner_d;
  logic     rr_q, pref;
  logic     pci_req_q, retry_q;
  logic [NCH-1:0] own_dma, bnd, release_dma, gap_busy, elig;
  logic     pci_rel, arb_free;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam owner_e MY = (k == 0) ? OWN_D0 : OWN_D1;
    logic [DLY_W-1:0] dly_k;
    assign dly_k          = dma_dly[k*DLY_W +: DLY_W];
    assign own_dma[k]     = (owner_q == MY);
    assign release_dma[k] = own_dma[k] && (bnd[k] || !dma_req[k]);
    assign elig[k]        = dma_req[k] && !gap_busy[k] && !(release_dma[k] && dly_k != '0);

    shbus_span #(.LINES_MAX(LINES_MAX), .DLY_W(DLY_W)) u_span (
      .clk(clk), .rst_n(rst_n), .own(own_dma[k]),
      .line_done(dma_line_done[k]), .last(dma_last[k]),
      .to_pci(dma_to_pci[k]), .wr(dma_wr[k]), .dly(dly_k),
      .boundary(bnd[k]));

    shbus_gap #(.DLY_W(DLY_W), .GAP_UNIT(GAP_UNIT)) u_gap (
      .clk(clk), .rst_n(rst_n), .done(release_dma[k]), .dly(dly_k),
      .busy(gap_busy[k]));

    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
      (own_dma[k] && !release_dma[k]) |=> dma_gnt[k]); // R6
    AST_GAP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      gap_busy[k] |-> !dma_gnt[k]); // R10
  end

  assign pci_rel  = (owner_q == OWN_PCI) && !pci_req;
  assign arb_free = (owner_q == OWN_IDLE) || pci_rel || (|release_dma);
  // A channel releasing this cycle hands preference to the other one.
  assign pref     = release_dma[0] ? 1'b1 : (release_dma[1] ? 1'b0 : rr_q);

  always_comb begin
    owner_d = owner_q;
    if (arb_free) begin
      if (pci_req)            owner_d = OWN_PCI;
      else if (elig == 2'b11) owner_d = pref ? OWN_D1 : OWN_D0;
      else if (elig[0])       owner_d = OWN_D0;
      else if (elig[1])       owner_d = OWN_D1;
      else                    owner_d = OWN_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q   <= OWN_IDLE;
      rr_q      <= 1'b0;
      pci_req_q <= 1'b0;
      retry_q   <= 1'b0;
    end else begin
      owner_q   <= owner_d;
      rr_q      <= pref;
      pci_req_q <= pci_req;
      retry_q   <= pci_req && !pci_req_q && (|own_dma) && !(|release_dma);
    end
  end

  assign pci_gnt   = (owner_q == OWN_PCI);
  assign dma_gnt   = own_dma;
  assign pci_retry = retry_q;

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pci_gnt, dma_gnt})); // R11
  AST_PCI_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_free && pci_req) |=> pci_gnt); // R2
  AST_PCI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_gnt && pci_req) |=> pci_gnt); // R4
  AST_RETRY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pci_retry |=> !pci_retry); // R5
  AST_RETRY_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    pci_retry |-> $past(|dma_gnt)); // R5
endmodule

// File: tb/tb_shbus_arbiter.sv
`timescale 1ns/1ps
module tb_shbus_arbiter;
  logic clk = 1'b0;
  logic rst_n;
  logic pci_req;
  logic [1:0] dma_req, dma_to_pci, dma_wr, dma_line_done, dma_last;
  logic [3:0] dma_dly;
  logic pci_gnt, pci_retry;
  logic [1:0] dma_gnt;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  shbus_arbiter dut (
    .clk(clk), .rst_n(rst_n), .pci_req(pci_req), .dma_req(dma_req),
    .dma_to_pci(dma_to_pci), .dma_wr(dma_wr), .dma_dly(dma_dly),
    .dma_line_done(dma_line_done), .dma_last(dma_last),
    .pci_gnt(pci_gnt), .pci_retry(pci_retry), .dma_gnt(dma_gnt));

  // {to_pci, wr, dly[1:0], expected lines[7:0]}
  localparam logic [11:0] VEC [6] = '{
    {1'b0, 1'b1, 2'd0, 8'd1},    // R7 write
    {1'b0, 1'b0, 2'd0, 8'd2},    // R7 read
    {1'b0, 1'b0, 2'd2, 8'd1},    // R8 read spaced
    {1'b0, 1'b1, 2'd1, 8'd1},    // R8 write spaced
    {1'b1, 1'b0, 2'd0, 8'd128},  // R9 stream
    {1'b1, 1'b0, 2'd3, 8'd1}     // R8 stream spaced
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic line(input int k, input bit lst);
    dma_line_done[k] = 1'b1;
    dma_last[k] = lst;
    tick();
    dma_line_done = '0;
    dma_last = '0;
  endtask

  task automatic idle_all();
    pci_req = 1'b0;
    dma_req = '0;
    repeat (20) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int got, idle;
    rst_n = 1'b0; pci_req = 1'b0; dma_req = '0; dma_to_pci = '0; dma_wr = '0;
    dma_dly = '0; dma_line_done = '0; dma_last = '0;
    dma_req = 2'b11; pci_req = 1'b1;
    repeat (3) tick();
    chk(!pci_gnt && dma_gnt == 2'b00 && !pci_retry, "R1 reset outputs",
        {pci_gnt, dma_gnt, pci_retry}, 0);
    pci_req = 1'b0; dma_req = '0;
    rst_n = 1'b1;
    tick();
    chk(!pci_gnt && dma_gnt == 2'b00, "R1 idle after reset", {pci_gnt, dma_gnt}, 0);

    // R3: alternation, channel 0 first after reset
    dma_wr = 2'b11;
    dma_req = 2'b11;
    tick();
    chk(dma_gnt == 2'b01, "R3 first grant ch0", dma_gnt, 1);
    line(0, 1'b0);
    chk(dma_gnt == 2'b10, "R3 hand-off to ch1", dma_gnt, 2);
    line(1, 1'b0);
    chk(dma_gnt == 2'b01, "R3 back to ch0", dma_gnt, 1);
    dma_req = '0;
    tick(); tick();

    // R2 / R4: PCI beats both channels and holds
    pci_req = 1'b1; dma_req = 2'b11;
    tick();
    chk(pci_gnt && dma_gnt == 2'b00, "R2 PCI wins at idle", {pci_gnt, dma_gnt}, 4);
    chk(!pci_retry, "R5 no retry when DMA idle", pci_retry, 0);
    repeat (3) tick();
    chk(pci_gnt, "R4 PCI grant held", pci_gnt, 1);
    pci_req = 1'b0;
    tick();
    // ch0 released last, so ch1 preferred; PCI grant left pointer alone
    chk(!pci_gnt && dma_gnt == 2'b10, "R3 pointer kept over PCI grant", {pci_gnt, dma_gnt}, 2);
    idle_all();

    // Table walk: R5 retry, R6 hold, R7/R8/R9 span length
    for (int i = 0; i < 6; i++) begin
      dma_to_pci[0] = VEC[i][11];
      dma_wr[0]     = VEC[i][10];
      dma_dly[1:0]  = VEC[i][9:8];
      dma_req[0]    = 1'b1;
      tick();
      chk(dma_gnt == 2'b01, "R6 table grant ch0", dma_gnt, 1);
      pci_req = 1'b1;
      tick();
      chk(pci_retry && dma_gnt == 2'b01, "R5 retry pulse", {pci_retry, dma_gnt}, 5);
      tick();
      chk(!pci_retry, "R5 retry one cycle", pci_retry, 0);
      got = 0;
      for (int n = 1; n <= 200; n++) begin
        line(0, 1'b0);
        if (pci_gnt) begin
          got = n;
          break;
        end
      end
      chk(got == int'(VEC[i][7:0]), "R7 R8 R9 R6 lines to boundary", got, int'(VEC[i][7:0]));
      idle_all();
    end

    // R9 early end via dma_last
    dma_to_pci[0] = 1'b1; dma_wr[0] = 1'b0; dma_dly[1:0] = 2'd0;
    dma_req[0] = 1'b1;
    tick();
    pci_req = 1'b1;
    tick();
    line(0, 1'b0);
    line(0, 1'b0);
    chk(!pci_gnt && dma_gnt == 2'b01, "R9 stream continues", {pci_gnt, dma_gnt}, 1);
    line(0, 1'b1);
    chk(pci_gnt, "R9 last ends stream", pci_gnt, 1);
    idle_all();

    // R10 spacing gap, code 1 and code 2
    for (int g = 1; g <= 2; g++) begin
      dma_to_pci[0] = 1'b0; dma_wr[0] = 1'b1; dma_dly[1:0] = 2'(g);
      dma_req[0] = 1'b1;
      tick();
      chk(dma_gnt == 2'b01, "R10 grant before gap", dma_gnt, 1);
      line(0, 1'b0);
      idle = 0;
      while (dma_gnt == 2'b00 && idle < 50) begin
        idle++;
        tick();
      end
      chk(idle == 4 * g, "R10 idle cycles of gap", idle, 4 * g);
      idle_all();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule